// File: doc/BRIEF.md
# Write-Port Read Violation Monitor

This block sits passively on the bus of an 8-bit processor and spots reads that land in the write-only half of RAM mapped into the 4 KiB cartridge space. Such RAM is usually reached at one address range for writes and another for reads. A read from the write range corrupts the RAM, so the monitor reports it to a debug host.

During each instruction the monitor keeps the address of the latest read and the latest write. When the next opcode fetch begins, it forms an effective read address. A read-modify-write instruction reads and writes the same location, and that read is not reported. The effective address is tested against a table of up to eight RAM windows. Each window gives a start, a size and a write offset, all in the 12-bit cartridge space. The result for the instruction is presented on an output. A sticky flag and a latched address hold the violation until the host acknowledges it.

Top module: `wport_read_monitor`

## Requirements
- R1: After reset, `violFlag` is 0, and `violAddr` and `resultAddr` are 0. Window 0 is valid with start 0x080, size 0x080 and write offset 0. All other windows are invalid.
- R2: A bus cycle is a read when `busRead`=1 and a write when `busRead`=0, qualified by `busValid`. Every read cycle replaces the captured last-read address. Every write cycle replaces the captured last-write address. A cycle with `instStart`=1 is the opcode fetch. On that cycle the captures and the written-this-instruction state are cleared, and the fetch itself is then captured.
- R3: If no write occurred during the instruction, the effective read address is the last-read address.
- R4: If a write occurred during the instruction, the effective read address is the last-read address when it differs from the last-write address, and 0 when they are equal.
- R5: A violation requires bit 12 of the effective address to be 1. Only bits 11:0 take part in the window comparison and in the reported value.
- R6: A window matches when it is valid and lo <= addr < hi. Here lo = (start + woff) mod 4096 and hi = (lo + size) mod 4096. A match in any window counts.
- R7: On every opcode-fetch cycle, the instruction that just ended is evaluated. `resultAddr` then takes the masked address if it is a violation, and 0 otherwise. The new value appears after that cycle's clock edge.
- R8: A violation sets `violFlag` and loads `violAddr`, and a later violation overwrites `violAddr`. A `hostAck` cycle clears both to 0. When an acknowledge and a violation fall in the same cycle, the violation wins.
- R9: A cycle with `cfgWe`=1 loads window `cfgIdx` with `cfgValid`, `cfgStart`, `cfgSize` and `cfgWoff`. The new contents are used by evaluations in later cycles. Invalid windows never match.
- R10: A window whose hi bound wraps to a value at or below lo, or whose size is 0, matches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | A bus cycle occurs this clock |
| busRead | input | 1 | 1 = read cycle, 0 = write cycle |
| busAddr | input | 16 | Bus address |
| instStart | input | 1 | This cycle is an opcode fetch |
| hostAck | input | 1 | Clear the sticky flag and the latched address |
| cfgWe | input | 1 | Load a window entry |
| cfgIdx | input | 3 | Window index to load |
| cfgValid | input | 1 | Valid bit for the entry |
| cfgStart | input | 12 | Window start |
| cfgSize | input | 12 | Window size |
| cfgWoff | input | 12 | Write offset of the window |
| resultAddr | output | 12 | Result of the last evaluated instruction (0 = none) |
| violFlag | output | 1 | Sticky violation flag |
| violAddr | output | 12 | Address of the latest violation |

## Verification
The embedded assertions check four things on every cycle. An opcode fetch leaves its own address as the effective address. A same-address read after a write inside one instruction gives zero. The sticky flag rises only at an evaluation. The flag and latch hold still without an evaluation or acknowledge, and an acknowledge clears them. Address-space selection by bit 12 is also checked on every cycle. The window arithmetic is shown only by the bench's scenarios:
- offset bounds and the exclusive upper edge;
- wrapped and empty windows;
- invalidation;
- any-window matching;
- reprogramming the table between instructions.

// File: rtl/wprm_pkg.sv
package wprm_pkg;
  parameter int ADDR_W = 16;
  parameter int CART_W = 12;

  // strobes and data passed from capture control to the window datapath
  typedef struct packed {
    logic              evalStb;
    logic              ackStb;
    logic              cartSel;
    logic [CART_W-1:0] effLow;
  } ctrlStb_t;

  typedef struct packed {
    logic              valid;
    logic [CART_W-1:0] start;
    logic [CART_W-1:0] size;
    logic [CART_W-1:0] woff;
  } window_t;
endpackage

// File: rtl/wprm_capture.sv
module wprm_capture
  import wprm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              instStart,
  input  logic              hostAck,
  output ctrlStb_t          stb
);
  logic [ADDR_W-1:0] lastRead, lastWrite, effAddr;
  logic              wroteQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastRead  <= '0;
      lastWrite <= '0;
      wroteQ    <= 1'b0;
    end else if (busValid) begin
      if (instStart) begin
        // clear for the new instruction, then capture the fetch itself
        lastRead  <= busRead ? busAddr : '0;
        lastWrite <= busRead ? '0 : busAddr;
        wroteQ    <= !busRead;
      end else if (busRead) begin
        lastRead <= busAddr;
      end else begin
        lastWrite <= busAddr;
        wroteQ    <= 1'b1;
      end
    end
  end

  always_comb begin
    if (!wroteQ)                     effAddr = lastRead;
    else if (lastRead != lastWrite)  effAddr = lastRead;
    else                             effAddr = '0;
  end

  always_comb begin
    stb.evalStb = busValid && instStart;
    stb.ackStb  = hostAck;
    stb.cartSel = effAddr[CART_W];
    stb.effLow  = effAddr[CART_W-1:0];
  end

  // R2: an opcode fetch read becomes the effective address of the new instruction
  assert_fetch_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && instStart && busRead) |=>
      (stb.cartSel == $past(busAddr[CART_W]) && stb.effLow == $past(busAddr[CART_W-1:0])));

  // R4: a read of the written address after a write yields zero
  assert_rmw_suppress_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !instStart && busRead && wroteQ && busAddr == lastWrite) |=>
      (!stb.cartSel && stb.effLow == '0));
endmodule

// File: rtl/wprm_table.sv
module wprm_table
  import wprm_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int IW        = $clog2(NUM_WIN),
  parameter int DEF_START = 'h080,
  parameter int DEF_SIZE  = 'h080,
  parameter int DEF_WOFF  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              cfgWe,
  input  logic [IW-1:0]     cfgIdx,
  input  logic              cfgValid,
  input  logic [CART_W-1:0] cfgStart,
  input  logic [CART_W-1:0] cfgSize,
  input  logic [CART_W-1:0] cfgWoff,
  output logic [CART_W-1:0] resultAddr,
  output logic              violFlag,
  output logic [CART_W-1:0] violAddr
);
  logic [NUM_WIN-1:0] winHit;
  logic               violNow;

  for (genvar g = 0; g < NUM_WIN; g++) begin : gWin
    window_t           win;
    logic [CART_W-1:0] loB, hiB;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        if (g == 0) begin
          win.valid <= 1'b1;
          win.start <= CART_W'(DEF_START);
          win.size  <= CART_W'(DEF_SIZE);
          win.woff  <= CART_W'(DEF_WOFF);
        end else begin
          win <= '0;
        end
      end else if (cfgWe && cfgIdx == IW'(g)) begin
        win.valid <= cfgValid;
        win.start <= cfgStart;
        win.size  <= cfgSize;
        win.woff  <= cfgWoff;
      end
    end

    always_comb begin
      loB       = win.start + win.woff;
      hiB       = loB + win.size;
      winHit[g] = win.valid && (stb.effLow >= loB) && (stb.effLow < hiB);
    end
  end

  assign violNow = stb.cartSel && (|winHit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultAddr <= '0;
      violFlag   <= 1'b0;
      violAddr   <= '0;
    end else begin
      if (stb.evalStb)
        resultAddr <= violNow ? stb.effLow : '0;
      if (stb.evalStb && violNow) begin
        violFlag <= 1'b1;
        violAddr <= stb.effLow;
      end else if (stb.ackStb) begin
        violFlag <= 1'b0;
        violAddr <= '0;
      end
    end
  end

  // R8: flag only rises at an instruction evaluation
  assert_flag_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(violFlag) |-> $past(stb.evalStb));

  // R8: acknowledge without evaluation clears flag and address
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackStb && !stb.evalStb) |=> (!violFlag && violAddr == '0));

  // R8: nothing moves the sticky state without evaluation or acknowledge
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.ackStb && !stb.evalStb) |=> ($stable(violFlag) && $stable(violAddr)));

  // R5: outside the cartridge space the result is zero
  assert_cart_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.evalStb && !stb.cartSel) |=> (resultAddr == '0));
endmodule

// File: rtl/wport_read_monitor.sv
module wport_read_monitor
  import wprm_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int IW     = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              instStart,
  input  logic              hostAck,
  input  logic              cfgWe,
  input  logic [IW-1:0]     cfgIdx,
  input  logic              cfgValid,
  input  logic [CART_W-1:0] cfgStart,
  input  logic [CART_W-1:0] cfgSize,
  input  logic [CART_W-1:0] cfgWoff,
  output logic [CART_W-1:0] resultAddr,
  output logic              violFlag,
  output logic [CART_W-1:0] violAddr
);
  ctrlStb_t stb;

  wprm_capture uCapture (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busRead(busRead),
    .busAddr(busAddr), .instStart(instStart), .hostAck(hostAck), .stb(stb)
  );

  wprm_table #(.NUM_WIN(NUM_WIN), .IW(IW)) uTable (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgValid(cfgValid),
    .cfgStart(cfgStart), .cfgSize(cfgSize), .cfgWoff(cfgWoff),
    .resultAddr(resultAddr), .violFlag(violFlag), .violAddr(violAddr)
  );
endmodule

// File: tb/tb_wport_read_monitor.sv
module tb_wport_read_monitor;
  logic        clk = 1'b0;
  logic        rstN, busValid, busRead, instStart, hostAck;
  logic [15:0] busAddr;
  logic        cfgWe, cfgValid;
  logic [2:0]  cfgIdx;
  logic [11:0] cfgStart, cfgSize, cfgWoff;
  logic [11:0] resultAddr, violAddr;
  logic        violFlag;

  int total = 0;
  int bad   = 0;

  // bench model
  logic        mV [8];
  logic [11:0] mS [8], mZ [8], mW [8];
  logic [15:0] mLR, mLW;
  logic        mWrote, mFlag;
  logic [11:0] mRes, mLatch;

  always #10 clk = ~clk;

  wport_read_monitor dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busRead(busRead),
    .busAddr(busAddr), .instStart(instStart), .hostAck(hostAck),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgValid(cfgValid),
    .cfgStart(cfgStart), .cfgSize(cfgSize), .cfgWoff(cfgWoff),
    .resultAddr(resultAddr), .violFlag(violFlag), .violAddr(violAddr)
  );

  function automatic logic [15:0] effModel();
    if (!mWrote) return mLR;
    return (mLR != mLW) ? mLR : 16'h0;
  endfunction

  function automatic logic hitModel(input logic [15:0] a);
    logic h = 1'b0;
    if (!a[12]) return 1'b0;
    for (int i = 0; i < 8; i++) begin
      logic [11:0] lo, hi;
      lo = mS[i] + mW[i];
      hi = lo + mZ[i];
      if (mV[i] && a[11:0] >= lo && a[11:0] < hi) h = 1'b1;
    end
    return h;
  endfunction

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check(tag, resultAddr, mRes, "resultAddr");
    check(tag, {11'd0, violFlag}, {11'd0, mFlag}, "violFlag");
    check(tag, violAddr, mLatch, "violAddr");
  endtask

  // one bus cycle; inputs driven at negedge, outputs checked at next negedge
  task automatic cyc(input logic rd, input logic [15:0] a, input logic inst,
                     input logic ack, input string tag);
    logic [15:0] e;
    logic h;
    busValid = 1'b1; busRead = rd; busAddr = a; instStart = inst; hostAck = ack;
    if (inst) begin
      e = effModel();
      h = hitModel(e);
      mRes = h ? e[11:0] : 12'h0;
    end else h = 1'b0;
    if (inst && h) begin mFlag = 1'b1; mLatch = e[11:0]; end
    else if (ack) begin mFlag = 1'b0; mLatch = 12'h0; end
    if (inst) begin
      mLR = rd ? a : 16'h0; mLW = rd ? 16'h0 : a; mWrote = !rd;
    end else if (rd) mLR = a;
    else begin mLW = a; mWrote = 1'b1; end
    @(posedge clk); @(negedge clk);
    busValid = 1'b0; hostAck = 1'b0; instStart = 1'b0;
    checkAll(tag);
  endtask

  task automatic ackOnly(input string tag);
    hostAck = 1'b1; busValid = 1'b0;
    mFlag = 1'b0; mLatch = 12'h0;
    @(posedge clk); @(negedge clk);
    hostAck = 1'b0;
    checkAll(tag);
  endtask

  task automatic cfg(input int idx, input logic v, input logic [11:0] s,
                     input logic [11:0] z, input logic [11:0] w);
    cfgWe = 1'b1; cfgIdx = 3'(idx); cfgValid = v; cfgStart = s; cfgSize = z; cfgWoff = w;
    @(posedge clk); @(negedge clk);
    cfgWe = 1'b0;
    mV[idx] = v; mS[idx] = s; mZ[idx] = z; mW[idx] = w;
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; busValid = 1'b0; busRead = 1'b1; busAddr = 16'h0;
    instStart = 1'b0; hostAck = 1'b0; cfgWe = 1'b0; cfgIdx = '0;
    cfgValid = 1'b0; cfgStart = '0; cfgSize = '0; cfgWoff = '0;
    for (int i = 0; i < 8; i++) begin mV[i] = 1'b0; mS[i] = '0; mZ[i] = '0; mW[i] = '0; end
    mV[0] = 1'b1; mS[0] = 12'h080; mZ[0] = 12'h080;
    mLR = '0; mLW = '0; mWrote = 1'b0; mFlag = 1'b0; mRes = '0; mLatch = '0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 reset");

    // R1 R6 default window, no write: R3
    cyc(1, 16'hE000, 1, 0, "R2 fetch");
    cyc(1, 16'h1085, 0, 0, "R3 read");
    cyc(1, 16'hE002, 1, 0, "R1 R3 default window hit");
    check("R7 result", resultAddr, 12'h085, "direct");
    // R4 read-modify-write same address: suppressed
    cyc(1, 16'h1090, 0, 0, "R4 read");
    cyc(0, 16'h1090, 0, 0, "R4 write");
    cyc(1, 16'hE004, 1, 0, "R4 rmw suppressed");
    check("R4 result", resultAddr, 12'h000, "direct");
    // R4 write to other address: reported
    cyc(1, 16'h1091, 0, 0, "R4 read");
    cyc(0, 16'h1010, 0, 0, "R4 write");
    cyc(1, 16'hE006, 1, 0, "R4 differing write");
    check("R8 latch", violAddr, 12'h091, "direct");
    // R2 last read wins; R5 bit 12 clear
    cyc(1, 16'h1085, 0, 0, "R2 read a");
    cyc(1, 16'h0085, 0, 0, "R2 read b");
    cyc(1, 16'hE008, 1, 0, "R2 R5 no cart bit");
    check("R5 result", resultAddr, 12'h000, "direct");
    // R5 mask high bits
    cyc(1, 16'h7081, 0, 0, "R5 read");
    cyc(1, 16'hE00A, 1, 0, "R5 masked report");
    check("R5 masked", resultAddr, 12'h081, "direct");
    // R8 ack clears, later violation overwrites, simultaneous ack loses
    ackOnly("R8 ack");
    check("R8 cleared", {11'd0, violFlag}, 12'h0, "direct");
    cyc(1, 16'h10FF, 0, 0, "R8 read");
    cyc(1, 16'hE00C, 1, 1, "R8 ack with violation");
    check("R8 ack loses", {11'd0, violFlag}, 12'h1, "direct");
    // R9 new window with offset, exclusive upper edge
    cfg(1, 1, 12'h200, 12'h040, 12'h400);
    cyc(1, 16'h163F, 0, 0, "R9 read");
    cyc(1, 16'hE00E, 1, 0, "R9 last in window");
    check("R9 hit", resultAddr, 12'h63F, "direct");
    cyc(1, 16'h1640, 0, 0, "R9 read");
    cyc(1, 16'hE010, 1, 0, "R9 upper edge");
    check("R9 miss", resultAddr, 12'h000, "direct");
    cyc(1, 16'h1200, 0, 0, "R6 read");
    cyc(1, 16'hE012, 1, 0, "R6 start without offset");
    // R10 wrap and empty
    cfg(2, 1, 12'hFF0, 12'h020, 12'h000);
    cfg(3, 1, 12'h300, 12'h000, 12'h000);
    cyc(1, 16'h1FF5, 0, 0, "R10 read");
    cyc(1, 16'hE014, 1, 0, "R10 wrapped");
    cyc(1, 16'h1300, 0, 0, "R10 read");
    cyc(1, 16'hE016, 1, 0, "R10 empty");
    check("R10 empty", resultAddr, 12'h000, "direct");
    // R9 invalidate default window
    cfg(0, 0, 12'h080, 12'h080, 12'h000);
    cyc(1, 16'h1085, 0, 0, "R9 read");
    cyc(1, 16'hE018, 1, 0, "R9 invalid window");
    check("R9 invalid", resultAddr, 12'h000, "direct");

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      int len;
      logic [15:0] a;
      if (($urandom % 40) == 0)
        cfg($urandom % 8, ($urandom % 4) != 0, 12'($urandom), 12'($urandom % 512), 12'($urandom));
      if (($urandom % 10) == 0) ackOnly("R8 random ack");
      a = (($urandom % 2) == 0) ? (16'hE000 | 16'($urandom % 4096)) : 16'($urandom);
      cyc(1, a, 1, ($urandom % 8) == 0, "R7 random eval");
      len = $urandom % 5;
      for (int k = 0; k < len; k++) begin
        logic rd;
        rd = ($urandom % 3) != 0;
        if (!rd && ($urandom % 2) == 0) a = mLR;
        else if (($urandom % 3) != 0) a = 16'h1000 | 16'($urandom % 4096);
        else a = 16'($urandom);
        cyc(rd, a, 0, ($urandom % 16) == 0, "R6 random body");
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule